// File: doc/BRIEF.md
# Half-Cycle Duration Tone Encoder

This block turns short data packets into one continuous square-wave tone for a narrowband radio modulator. The tone never stops. Its information lies only in how long each level lasts: every half-cycle is either long (two units) or short (one unit). When there is nothing to send, the block repeats long half-cycles as an idle preamble. A packet begins with a run of short half-cycles, continues with the link address, and ends with three byte slots. Every two data bits become a group of four half-cycles with two long and two short ones, so the tone stays balanced for an AC-coupled receiver.

A host hands over one packet at a time through a valid/ready handshake. The packet carries three bytes and a per-byte keep mask, and the address is sampled when the packet is accepted. For bench tests of the radio, a test-mode input replaces the encoded stream with a flat low level, a steady long-half-cycle tone or a steady short-half-cycle tone. The half-cycle unit is a parameter given in clock cycles. For example, 3125 cycles at 100 MHz gives the 31.25 µs short half-cycle, so the 62.5 µs long one forms an 8 kHz tone and a run of short ones forms a 16 kHz tone.

Top module: `tone_encoder`

## Requirements
- R1: Outside the flat test mode, the tone holds each level for exactly SHORT_TICKS clock cycles (short) or 2*SHORT_TICKS cycles (long), and it toggles at every half-cycle boundary.
- R2: While no packet is held and test_mode is 0, every half-cycle is long.
- R3: A packet is 64 half-cycles: one sync group of four short half-cycles, then three address groups, then twelve data groups. It is followed by long idle half-cycles.
- R4: A group of four half-cycles carries a 2-bit symbol as follows, in time order: 00 gives long,long,short,short; 01 gives long,short,short,long; 10 gives short,long,long,short; 11 gives short,short,long,long.
- R5: Address group k (k = 0..2) sends the symbol {0, addr[2-k]}. The address is the value on addr in the cycle the packet is accepted.
- R6: The byte slots go out in the order pkt_data[7:0], pkt_data[15:8], pkt_data[23:16]. Each byte is sent as four symbols, starting with bits [7:6].
- R7: A byte slot whose bit in pkt_keep is 0 is sent as four groups made only of long half-cycles.
- R8: pkt_ready is high only when test_mode is 0 and no packet is held. It goes low in the cycle after an accept and stays low until the packet's last half-cycle has ended.
- R9: test_mode 1 drives the tone low from the next cycle onward. test_mode 2 gives only long half-cycles and test_mode 3 gives only short ones. A switch between steady kinds takes effect at a half-cycle boundary.
- R10: Any nonzero test_mode drops pkt_ready and discards a held packet, so pkt_ready is high again as soon as test_mode returns to 0.
- R11: After reset the tone is low and pkt_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet slot free |
| pkt_data | input | 24 | Three byte slots, slot 0 in bits [7:0] |
| pkt_keep | input | 3 | Per-slot keep bit; 0 pads the slot with idle |
| addr | input | 3 | Link address, sampled on accept |
| test_mode | input | 2 | 0 normal, 1 flat low, 2 steady long, 3 steady short |
| tone | output | 1 | Encoded square-wave tone |

## Verification
The bench times every tone level and turns a packet's half-cycles back into a long/short map. It then compares that map with one worked out separately for each region. Random data, keep masks and addresses test the symbol map, the byte order and the padding together. One directed byte that uses all four symbols in turn pins the map itself (R4). Masks with all slots padded and with all slots kept, and addresses 0 and 7, reach the edges of the sync and address fields. The addr input is changed after each accept, which shows the address is latched at the handshake. Each steady test mode is timed on its own. A packet cut off by a test mode shows whether the slot is freed.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_FLAT   = 2'd1,
    TM_SLOW   = 2'd2,
    TM_FAST   = 2'd3
  } tmode_e;

  localparam int HALVES_PER_GROUP = 4;
  localparam int BITS_PER_GROUP   = 2;
  localparam int GROUPS_PER_BYTE  = 8 / BITS_PER_GROUP;

  // Bit h set means half-cycle h of the group is short (h = 0 first in time).
  function automatic logic [3:0] short_slots(input logic [1:0] sym);
    logic [3:0] m;
    case (sym)
      2'b00:   m = 4'b1100;
      2'b01:   m = 4'b0110;
      2'b10:   m = 4'b1001;
      default: m = 4'b0011;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tone_frame_map.sv
module tone_frame_map
  import tone_pkg::*;
#(
  parameter int BYTES  = 3,
  parameter int ADDR_W = 3,
  parameter int IDX_W  = 6
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTES*8-1:0] data,
  input  logic [BYTES-1:0]   keep,
  output logic               is_short
);

  localparam int DATA_GROUPS = BYTES * GROUPS_PER_BYTE;
  localparam int GROUPS      = 1 + ADDR_W + DATA_GROUPS;

  logic [1:0]        grp_sym [GROUPS];
  logic [GROUPS-1:0] grp_all_short;
  logic [GROUPS-1:0] grp_pad;

  // group 0: sync, all short
  assign grp_sym[0]       = 2'b00;
  assign grp_all_short[0] = 1'b1;
  assign grp_pad[0]       = 1'b0;

  for (genvar a = 0; a < ADDR_W; a++) begin : g_addr
    assign grp_sym[1+a]       = {1'b0, addr[ADDR_W-1-a]};
    assign grp_all_short[1+a] = 1'b0;
    assign grp_pad[1+a]       = 1'b0;
  end

  for (genvar d = 0; d < DATA_GROUPS; d++) begin : g_data
    localparam int BY = d / GROUPS_PER_BYTE;
    localparam int SL = d % GROUPS_PER_BYTE;
    assign grp_sym[1+ADDR_W+d]       = data[8*BY + 7 - 2*SL -: 2];
    assign grp_all_short[1+ADDR_W+d] = 1'b0;
    assign grp_pad[1+ADDR_W+d]       = ~keep[BY];
  end

  logic [IDX_W-3:0] g;
  logic [1:0]       h;
  logic [3:0]       slots;

  always_comb begin
    g        = idx[IDX_W-1:2];
    h        = idx[1:0];
    slots    = 4'b0000;
    is_short = 1'b0;
    if (int'(g) < GROUPS) begin
      slots    = short_slots(grp_sym[g]);
      is_short = grp_all_short[g] | (~grp_pad[g] & slots[h]);
    end
  end

endmodule

// File: rtl/tone_sequencer.sv
module tone_sequencer
  import tone_pkg::*;
#(
  parameter int BYTES  = 3,
  parameter int ADDR_W = 3,
  parameter int IDX_W  = 6,
  parameter int HALVES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  tmode_e             mode,
  input  logic               boundary,
  input  logic               pkt_valid,
  output logic               pkt_ready,
  input  logic [BYTES*8-1:0] pkt_data,
  input  logic [BYTES-1:0]   pkt_keep,
  input  logic [ADDR_W-1:0]  addr,
  output logic               next_short
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(HALVES - 1);

  logic               loaded, running;
  logic [IDX_W-1:0]   idx, map_idx;
  logic [BYTES*8-1:0] lat_data;
  logic [BYTES-1:0]   lat_keep;
  logic [ADDR_W-1:0]  lat_addr;
  logic               map_short, at_last, accept;

  assign pkt_ready = ~loaded & (mode == TM_NORMAL);
  assign accept    = pkt_valid & pkt_ready;
  assign at_last   = running & (idx == LAST);
  assign map_idx   = running ? idx + 1'b1 : '0;

  tone_frame_map #(
    .BYTES (BYTES),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_map (
    .idx     (map_idx),
    .addr    (lat_addr),
    .data    (lat_data),
    .keep    (lat_keep),
    .is_short(map_short)
  );

  always_comb begin
    case (mode)
      TM_FAST: next_short = 1'b1;
      TM_SLOW: next_short = 1'b0;
      TM_FLAT: next_short = 1'b0;
      default: next_short = ((running & ~at_last) | (~running & loaded)) & map_short;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded   <= 1'b0;
      running  <= 1'b0;
      idx      <= '0;
      lat_data <= '0;
      lat_keep <= '0;
      lat_addr <= '0;
    end else if (mode != TM_NORMAL) begin
      loaded  <= 1'b0;
      running <= 1'b0;
      idx     <= '0;
    end else begin
      if (accept) begin
        loaded   <= 1'b1;
        lat_data <= pkt_data;
        lat_keep <= pkt_keep;
        lat_addr <= addr;
      end
      if (boundary) begin
        if (running) begin
          if (at_last) begin
            running <= 1'b0;
            loaded  <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
          end
        end else if (loaded) begin
          running <= 1'b1;
          idx     <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/tone_halfcycle_timer.sv
module tone_halfcycle_timer #(
  parameter int SHORT_TICKS = 3125
) (
  input  logic clk,
  input  logic rst,
  input  logic flat,
  input  logic next_short,
  output logic boundary,
  output logic tone
);

  localparam int CNT_W = (2 * SHORT_TICKS > 1) ? $clog2(2 * SHORT_TICKS) : 1;
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(2 * SHORT_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign boundary = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tone <= 1'b0;
    end else if (flat) begin
      cnt  <= '0;
      tone <= 1'b0;
    end else if (boundary) begin
      tone <= ~tone;
      cnt  <= next_short ? SHORT_LOAD : LONG_LOAD;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/tone_encoder.sv
module tone_encoder
  import tone_pkg::*;
#(
  parameter int SHORT_TICKS = 3125,
  parameter int BYTES       = 3,
  parameter int ADDR_W      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkt_valid,
  output logic               pkt_ready,
  input  logic [BYTES*8-1:0] pkt_data,
  input  logic [BYTES-1:0]   pkt_keep,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         test_mode,
  output logic               tone
);

  localparam int GROUPS = 1 + ADDR_W + BYTES * GROUPS_PER_BYTE;
  localparam int HALVES = GROUPS * HALVES_PER_GROUP;
  localparam int IDX_W  = $clog2(HALVES);

  tmode_e mode;
  logic   boundary, next_short;

  assign mode = tmode_e'(test_mode);

  tone_sequencer #(
    .BYTES (BYTES),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .HALVES(HALVES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .boundary  (boundary),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_data  (pkt_data),
    .pkt_keep  (pkt_keep),
    .addr      (addr),
    .next_short(next_short)
  );

  tone_halfcycle_timer #(
    .SHORT_TICKS(SHORT_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .flat      (mode == TM_FLAT),
    .next_short(next_short),
    .boundary  (boundary),
    .tone      (tone)
  );

endmodule

// File: rtl/tone_encoder_checker.sv
module tone_encoder_checker #(
  parameter int SHORT_TICKS = 3125
) (
  input logic       clk,
  input logic       rst,
  input logic       pkt_valid,
  input logic       pkt_ready,
  input logic [1:0] test_mode,
  input logic       tone
);

  logic        prev_tone, seen, clean;
  logic [1:0]  prev_mode;
  logic [31:0] run;
  logic        toggled;

  assign toggled = (tone != prev_tone);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_tone <= 1'b0;
      prev_mode <= 2'd0;
      seen      <= 1'b0;
      clean     <= 1'b0;
      run       <= '0;
    end else begin
      prev_tone <= tone;
      prev_mode <= test_mode;
      if (toggled) begin
        run   <= 32'd1;
        seen  <= (test_mode != 2'd1);
        clean <= pkt_ready && (test_mode == 2'd0) && (prev_mode == 2'd0);
      end else begin
        run   <= run + 32'd1;
        clean <= clean && pkt_ready && (test_mode == 2'd0);
        if (test_mode == 2'd1) seen <= 1'b0;
      end
    end
  end

  // R1: every measured level lasts one or two units
  a_r1_halfcycle_len: assert property (@(posedge clk) disable iff (rst)
    (seen && toggled && test_mode != 2'd1) |->
      (run == 32'(SHORT_TICKS) || run == 32'(2 * SHORT_TICKS)));

  // R2: a half-cycle spent entirely idle is long
  a_r2_idle_long: assert property (@(posedge clk) disable iff (rst)
    (seen && clean && toggled) |-> (run == 32'(2 * SHORT_TICKS)));

  // R8: slot closes after an accept
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready) |=> !pkt_ready);

  // R10: no intake during test modes
  a_r10_no_ready_in_test: assert property (@(posedge clk) disable iff (rst)
    (test_mode != 2'd0) |-> !pkt_ready);

  // R9: flat mode holds the line low
  a_r9_flat_low: assert property (@(posedge clk) disable iff (rst)
    (test_mode == 2'd1) |=> !tone);

endmodule

bind tone_encoder tone_encoder_checker #(
  .SHORT_TICKS(SHORT_TICKS)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready),
  .test_mode(test_mode),
  .tone     (tone)
);

// File: tb/tone_encoder_test.sv
module tone_encoder_test;

  localparam int S = 3;
  localparam int L = 2 * S;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [23:0] pkt_data = '0;
  logic [2:0]  pkt_keep = '0;
  logic [2:0]  addr = '0;
  logic [1:0]  test_mode = 2'd0;
  logic        tone;

  int checks = 0;
  int fails  = 0;

  int   dur_q[$];
  int   run = 0;
  logic prev = 1'b0;
  logic [63:0] last_act;
  logic        last_found;

  always #5 clk = ~clk;

  tone_encoder #(.SHORT_TICKS(S), .BYTES(3), .ADDR_W(3)) uut (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_keep(pkt_keep), .addr(addr),
    .test_mode(test_mode), .tone(tone)
  );

  // level-duration monitor
  always @(negedge clk) begin
    if (rst) begin
      run  = 0;
      prev = tone;
    end else if (tone != prev) begin
      dur_q.push_back(run);
      run  = 1;
      prev = tone;
    end else begin
      run++;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input logic [1:0] sym);
    case (sym)
      2'b00:   return 4'b1100;
      2'b01:   return 4'b0110;
      2'b10:   return 4'b1001;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic [63:0] exp_mask(input logic [2:0] a, input logic [23:0] d,
                                           input logic [2:0] k);
    logic [63:0] m;
    logic [7:0]  byt;
    m = '0;
    m[3:0] = 4'hF;
    for (int g = 0; g < 3; g++) m[4+4*g +: 4] = pat({1'b0, a[2-g]});
    for (int b = 0; b < 3; b++) begin
      byt = d[8*b +: 8];
      for (int s = 0; s < 4; s++)
        if (k[b]) m[16+16*b+4*s +: 4] = pat(byt[7-2*s -: 2]);
    end
    return m;
  endfunction

  task automatic send_and_check(input logic [2:0] a, input logic [23:0] d,
                                input logic [2:0] k);
    int start, i, bad, lim;
    logic [63:0] exp;
    exp = exp_mask(a, d, k);
    lim = 0;
    while (!pkt_ready && lim < 2000) begin @(negedge clk); lim++; end
    start = dur_q.size();
    pkt_valid = 1'b1; pkt_data = d; pkt_keep = k; addr = a;
    @(negedge clk);
    pkt_valid = 1'b0;
    addr = 3'($urandom);
    check(!pkt_ready, "R8", "ready after accept", 64'(pkt_ready), 64'd0);
    lim = 0;
    while (!pkt_ready && lim < 2000) begin @(negedge clk); lim++; end
    repeat (4 * L) @(negedge clk);
    i = start;
    while (i < dur_q.size() && dur_q[i] == L) i++;
    last_found = (i + 65 <= dur_q.size());
    check(last_found, "R3", "packet located", 64'(dur_q.size() - i), 64'd65);
    if (!last_found) return;
    bad = 0;
    last_act = '0;
    for (int n = 0; n < 64; n++) begin
      if (dur_q[i+n] != S && dur_q[i+n] != L) bad++;
      last_act[n] = (dur_q[i+n] == S);
    end
    check(bad == 0, "R1", "half-cycle lengths", 64'(bad), 64'd0);
    check(last_act[3:0] == 4'hF, "R3", "sync group", 64'(last_act[3:0]), 64'hF);
    check(last_act[15:4] == exp[15:4], "R5", "address groups",
          64'(last_act[15:4]), 64'(exp[15:4]));
    check(last_act[63:16] == exp[63:16], (k == 3'b111) ? "R6" : "R7", "data groups",
          64'(last_act[63:16]), 64'(exp[63:16]));
    check(dur_q[i+64] == L, "R2", "idle after packet", 64'(dur_q[i+64]), 64'(L));
  endtask

  task automatic steady(input logic [1:0] m, input int len, input string req);
    int base, bad, cnt;
    @(negedge clk);
    test_mode = m;
    @(negedge clk);
    check(!pkt_ready, "R10", "ready in test mode", 64'(pkt_ready), 64'd0);
    repeat (30) @(negedge clk);
    base = dur_q.size();
    repeat (80) @(negedge clk);
    bad = 0; cnt = 0;
    for (int n = base; n < dur_q.size(); n++) begin
      cnt++;
      if (dur_q[n] != len) bad++;
    end
    check(bad == 0 && cnt >= 5, req, "steady tone lengths", 64'(bad), 64'd0);
    test_mode = 2'd0;
    repeat (3 * L) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R11: reset state
    check(tone == 1'b0, "R11", "tone in reset", 64'(tone), 64'd0);
    check(pkt_ready == 1'b1, "R11", "ready in reset", 64'(pkt_ready), 64'd1);
    rst = 1'b0;
    repeat (10 * L) @(negedge clk);

    // R2: idle stream only long
    bad = 0;
    for (int n = 1; n < dur_q.size(); n++) if (dur_q[n] != L) bad++;
    check(bad == 0 && dur_q.size() >= 5, "R2", "preamble lengths", 64'(bad), 64'd0);

    // R4: directed byte using all four symbols in order
    send_and_check(3'd5, 24'h00001B, 3'b001);
    if (last_found)
      check(last_act[31:16] == 16'h396C, "R4", "symbol map", 64'(last_act[31:16]), 64'h396C);

    // corners
    send_and_check(3'd0, 24'h000000, 3'b111);
    send_and_check(3'd7, 24'hFFFFFF, 3'b111);
    send_and_check(3'd2, 24'hA5C33C, 3'b000);
    send_and_check(3'd6, 24'h12AB34, 3'b101);

    // random
    for (int r = 0; r < 6; r++)
      send_and_check(3'($urandom), 24'($urandom), 3'($urandom));

    // R9: steady test tones
    steady(2'd2, L, "R9");
    steady(2'd3, S, "R9");

    // R9: flat low
    @(negedge clk);
    test_mode = 2'd1;
    repeat (2) @(negedge clk);
    bad = 0;
    repeat (60) begin
      if (tone != 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9", "flat level", 64'(bad), 64'd0);
    test_mode = 2'd0;
    repeat (4 * L) @(negedge clk);

    // R10: test mode discards a held packet
    while (!pkt_ready) @(negedge clk);
    pkt_valid = 1'b1; pkt_data = 24'h55AA55; pkt_keep = 3'b111; addr = 3'd3;
    @(negedge clk);
    pkt_valid = 1'b0;
    repeat (40) @(negedge clk);
    test_mode = 2'd3;
    repeat (20) @(negedge clk);
    test_mode = 2'd0;
    @(negedge clk);
    check(pkt_ready == 1'b1, "R10", "ready after test mode", 64'(pkt_ready), 64'd1);
    repeat (4 * L) @(negedge clk);
    send_and_check(3'd1, 24'hC0FFEE, 3'b111);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule